// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Plane

This block is the logic core of a small programmable logic device. A set of dedicated input signals and one feedback line per output are each presented to the array twice, once true and once inverted. Every row of the array is a product term: the AND of whichever of those literals its connection bits select. Fixed, unequal groups of rows are ORed into one sum per output. A further row per output produces an output-enable term, and two more rows give a global preset term and a global reset term. These feed the output cells and registers that sit outside this block.

The connection bits are loaded serially, one bit for each clock in which the shift strobe is high. The array stays blank, with every output at 0, from reset until a separate load strobe arms it, and again whenever shifting restarts. Once armed, the path from the inputs and feedback lines to every output is purely combinational.

Top module: `sop_plane`

## Requirements
- R1: Signal index s counts the dedicated inputs first (0 to N_IN-1), then the feedback lines (N_IN to N_IN+N_OUT-1). Column 2s is the true literal of signal s and column 2s+1 is its complement. A set connection bit puts that literal into the row's AND.
- R2: A row with no connection bits set evaluates to 1 while the array is armed.
- R3: A row that includes both the true and the complement literal of any signal always evaluates to 0.
- R4: Sum rows come first. Output k owns a contiguous block of BASE_TERMS + STEP_TERMS*min(k, N_OUT-1-k) rows, and each block starts where the previous one ends. With the defaults the block sizes are 8,10,12,14,16,16,14,12,10,8, which gives 120 rows.
- R5: sum_o[k] is the OR of the rows in output k's block.
- R6: oe_o[k] is the row that directly follows all sum rows, offset by k.
- R7: preset_o is the row after the enable rows, and reset_o is the last row.
- R8: Each clock with cfg_shift_i high takes in one bit from cfg_bit_i. When exactly rows×columns bits have been shifted, bit b of that stream (starting at 0) is the connection bit of row b / N_LIT and column b mod N_LIT.
- R9: A clock edge with cfg_load_i high and cfg_shift_i low arms the array from the next cycle. A clock edge with cfg_shift_i high blanks it from the next cycle, and this also applies when cfg_load_i is high in the same cycle. While the array is blank, all outputs are 0.
- R10: Reset blanks the array and sets every connection bit to 1, which is the erased state. A load given before any shifting therefore arms an array in which every output is 0.
- R11: Once armed, every output follows in_i and fb_i in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration chain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_shift_i | input | 1 | Shift one connection bit in |
| cfg_bit_i | input | 1 | Serial connection bit |
| cfg_load_i | input | 1 | Arm the array with the shifted configuration |
| in_i | input | N_IN | Dedicated inputs |
| fb_i | input | N_OUT | Feedback lines from the output cells |
| sum_o | output | N_OUT | Sum term for each output |
| oe_o | output | N_OUT | Output-enable term for each output |
| preset_o | output | 1 | Global synchronous-preset term |
| reset_o | output | 1 | Global asynchronous-reset term |

## Verification
The bench builds the plane with four inputs, four outputs, BASE_TERMS=2 and STEP_TERMS=1. This gives group sizes 2,3,3,2, 16 rows of 16 literals, and a 256-bit stream. A full reload therefore costs a few hundred cycles. With that cost, the bench can sweep every row on its own, by blanking all rows but one, so each group boundary and each control row is hit directly. It can also run many random configurations against a bench-side evaluator. The unequal, symmetric grouping rule still yields distinct sizes at these parameter values.

// File: rtl/sop_plane_pkg.sv
package sop_plane_pkg;

  // rows owned by output k: widest in the middle, narrowest at both ends
  function automatic int grp_size(int k, int n_out, int base, int step);
    int d;
    d = (k < n_out - 1 - k) ? k : n_out - 1 - k;
    return base + step * d;
  endfunction

  function automatic int grp_offset(int k, int n_out, int base, int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_size(j, n_out, base, step);
    return acc;
  endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int unsigned CFG_BITS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                load_i,
  output logic [CFG_BITS-1:0] cfg_o,
  output logic                armed_o
);

  logic [CFG_BITS-1:0] cfg_q;
  logic                armed_q;

  generate
    if (CFG_BITS == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cfg_q <= '1;
        else if (shift_i) cfg_q <= bit_i;
      end
    end else begin : g_chain
      // first bit shifted ends at index 0 after a full stream
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cfg_q <= '1;
        else if (shift_i) cfg_q <= {bit_i, cfg_q[CFG_BITS-1:1]};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (shift_i) armed_q <= 1'b0;
    else if (load_i)  armed_q <= 1'b1;
  end

  assign cfg_o   = cfg_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/sop_term_row.sv
module sop_term_row #(
  parameter int unsigned N_LIT = 4
) (
  input  logic             en_i,
  input  logic [N_LIT-1:0] mask_i,
  input  logic [N_LIT-1:0] lit_i,
  output logic             term_o
);

  // unselected columns read as 1; empty row is a constant 1
  assign term_o = en_i & (&(lit_i | ~mask_i));

endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
  parameter int unsigned SIZE = 8
) (
  input  logic [SIZE-1:0] terms_i,
  output logic            sum_o
);

  assign sum_o = |terms_i;

endmodule

// File: rtl/sop_plane.sv
module sop_plane
  import sop_plane_pkg::*;
#(
  parameter int unsigned N_IN       = 12,
  parameter int unsigned N_OUT      = 10,
  parameter int unsigned BASE_TERMS = 8,
  parameter int unsigned STEP_TERMS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_shift_i,
  input  logic             cfg_bit_i,
  input  logic             cfg_load_i,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_OUT-1:0] fb_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o,
  output logic             preset_o,
  output logic             reset_o
);

  localparam int unsigned N_SIG    = N_IN + N_OUT;
  localparam int unsigned N_LIT    = 2 * N_SIG;
  localparam int unsigned SUM_ROWS = grp_offset(N_OUT, N_OUT, BASE_TERMS, STEP_TERMS);
  localparam int unsigned OE_ROW0  = SUM_ROWS;
  localparam int unsigned PRE_ROW  = SUM_ROWS + N_OUT;
  localparam int unsigned RST_ROW  = PRE_ROW + 1;
  localparam int unsigned N_ROWS   = RST_ROW + 1;
  localparam int unsigned CFG_BITS = N_ROWS * N_LIT;

  logic [CFG_BITS-1:0] cfg;
  logic                armed;
  logic [N_SIG-1:0]    sig;
  logic [N_LIT-1:0]    lit;
  logic [N_ROWS-1:0]   term;

  sop_cfg_chain #(.CFG_BITS(CFG_BITS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (cfg_shift_i),
    .bit_i   (cfg_bit_i),
    .load_i  (cfg_load_i),
    .cfg_o   (cfg),
    .armed_o (armed)
  );

  assign sig = {fb_i, in_i};

  generate
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      assign lit[2*s]   = sig[s];
      assign lit[2*s+1] = ~sig[s];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      sop_term_row #(.N_LIT(N_LIT)) u_row (
        .en_i   (armed),
        .mask_i (cfg[r*N_LIT +: N_LIT]),
        .lit_i  (lit),
        .term_o (term[r])
      );
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_sum
      localparam int unsigned OFF = grp_offset(k, N_OUT, BASE_TERMS, STEP_TERMS);
      localparam int unsigned SZ  = grp_size(k, N_OUT, BASE_TERMS, STEP_TERMS);
      sop_or_group #(.SIZE(SZ)) u_or (
        .terms_i (term[OFF +: SZ]),
        .sum_o   (sum_o[k])
      );
    end
  endgenerate

  assign oe_o     = term[OE_ROW0 +: N_OUT];
  assign preset_o = term[PRE_ROW];
  assign reset_o  = term[RST_ROW];

endmodule

// File: rtl/sop_plane_chk.sv
module sop_plane_chk #(
  parameter int unsigned N_IN  = 12,
  parameter int unsigned N_OUT = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_shift_i,
  input logic             cfg_load_i,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] fb_i,
  input logic [N_OUT-1:0] sum_o,
  input logic [N_OUT-1:0] oe_o,
  input logic             preset_o,
  input logic             reset_o
);

  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        loaded_q <= 1'b0;
    else if (cfg_shift_i)               loaded_q <= 1'b0;
    else if (cfg_load_i)                loaded_q <= 1'b1;
  end

  // R9: a shift edge blanks every output in the following cycle
  a_r9_shift_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_shift_i |=> (sum_o == '0 && oe_o == '0 && !preset_o && !reset_o));

  // R10: from reset until a load, nothing drives high
  a_r10_unloaded_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> (sum_o == '0 && oe_o == '0 && !preset_o && !reset_o));

  // R11: with configuration untouched, sums move only with in_i/fb_i
  a_r11_sum_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(in_i) && $stable(fb_i) && !$past(cfg_shift_i) && !$past(cfg_load_i))
      |-> $stable(sum_o));

  // R11: same for the control terms
  a_r11_ctrl_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(in_i) && $stable(fb_i) && !$past(cfg_shift_i) && !$past(cfg_load_i))
      |-> ($stable(oe_o) && $stable(preset_o) && $stable(reset_o)));

endmodule

bind sop_plane sop_plane_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_shift_i (cfg_shift_i),
  .cfg_load_i  (cfg_load_i),
  .in_i        (in_i),
  .fb_i        (fb_i),
  .sum_o       (sum_o),
  .oe_o        (oe_o),
  .preset_o    (preset_o),
  .reset_o     (reset_o)
);

// File: tb/tb_sop_plane.sv
`timescale 1ns/1ps
module tb_sop_plane;

  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int BASE  = 2;
  localparam int STEP  = 1;
  localparam int NS    = N_IN + N_OUT;
  localparam int NL    = 2 * NS;

  function automatic int gsize(int k);
    return BASE + STEP * ((k < N_OUT - 1 - k) ? k : N_OUT - 1 - k);
  endfunction
  function automatic int gsum();
    int a;
    a = 0;
    for (int k = 0; k < N_OUT; k++) a += gsize(k);
    return a;
  endfunction

  localparam int SUMR = gsum();
  localparam int NR   = SUMR + N_OUT + 2;
  localparam int CB   = NR * NL;
  localparam int W    = 2 * N_OUT + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sh = 1'b0, cbit = 1'b0, ld = 1'b0;
  logic [N_IN-1:0]  in_v = '0;
  logic [N_OUT-1:0] fb_v = '0;
  logic [N_OUT-1:0] sum, oe;
  logic             pre, rs;
  logic [CB-1:0]    mdl;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sop_plane #(.N_IN(N_IN), .N_OUT(N_OUT), .BASE_TERMS(BASE), .STEP_TERMS(STEP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_shift_i(sh), .cfg_bit_i(cbit), .cfg_load_i(ld),
    .in_i(in_v), .fb_i(fb_v), .sum_o(sum), .oe_o(oe), .preset_o(pre), .reset_o(rs)
  );

  function automatic logic [W-1:0] expect_out(logic [CB-1:0] m, logic [N_IN-1:0] a,
                                              logic [N_OUT-1:0] f, bit arm);
    logic [NS-1:0] sg;
    logic [NR-1:0] rv;
    logic [N_OUT-1:0] s_e;
    int base;
    sg = {f, a};
    for (int r = 0; r < NR; r++) begin
      rv[r] = 1'b1;
      for (int s = 0; s < NS; s++) begin
        if (m[r*NL + 2*s]   && !sg[s]) rv[r] = 1'b0;
        if (m[r*NL + 2*s+1] &&  sg[s]) rv[r] = 1'b0;
      end
    end
    base = 0;
    for (int k = 0; k < N_OUT; k++) begin
      s_e[k] = 1'b0;
      for (int j = 0; j < gsize(k); j++) s_e[k] = s_e[k] | rv[base + j];
      base += gsize(k);
    end
    if (!arm) return '0;
    return {rv[NR-1], rv[SUMR+N_OUT], rv[SUMR +: N_OUT], s_e};
  endfunction

  task automatic chk(string tag, logic [W-1:0] exp);
    logic [W-1:0] got;
    got = {rs, pre, oe, sum};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic load_cfg(logic [CB-1:0] m);
    for (int b = 0; b < CB; b++) begin
      @(negedge clk); sh = 1'b1; cbit = m[b];
    end
    @(negedge clk); sh = 1'b0; cbit = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic apply(logic [N_IN-1:0] a, logic [N_OUT-1:0] f, bit armd, string tag);
    @(negedge clk); in_v = a; fb_v = f;
    #1 chk(tag, expect_out(mdl, a, f, armd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all R) got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R10: blank while in reset
    repeat (3) @(negedge clk);
    in_v = 4'hF; fb_v = 4'h0;
    #1 chk("R10 in reset", '0);
    @(negedge clk); rst_n = 1'b1;
    apply(4'h0, 4'hF, 1'b0, "R9 blank after reset");

    // R10: erased state armed directly: every row contradictory
    arm();
    mdl = '1;
    apply(4'h5, 4'hA, 1'b1, "R10 erased armed");
    apply(4'hF, 4'h0, 1'b1, "R10 erased armed");

    // R2: empty rows fire everything; R9: blank until armed
    mdl = '0;
    load_cfg(mdl);
    apply(4'h3, 4'h3, 1'b0, "R9 loaded not armed");
    arm();
    apply(4'h3, 4'h3, 1'b1, "R2 empty rows");
    chk("R2 all high", '1);

    // R3: contradict feedback signal 1 in the preset row only
    mdl = '0;
    mdl[(SUMR+N_OUT)*NL + 2*(N_IN+1)]   = 1'b1;
    mdl[(SUMR+N_OUT)*NL + 2*(N_IN+1)+1] = 1'b1;
    load_cfg(mdl); arm();
    apply(4'h0, 4'h0, 1'b1, "R3 contradiction");
    apply(4'hF, 4'hF, 1'b1, "R3 contradiction");

    // R4 R6 R7 R8: a single live row, swept over all rows
    for (int r = 0; r < NR; r++) begin
      mdl = '0;
      for (int q = 0; q < NR; q++)
        if (q != r) begin mdl[q*NL] = 1'b1; mdl[q*NL+1] = 1'b1; end
      load_cfg(mdl); arm();
      apply(4'h9, 4'h6, 1'b1, "R4 R6 R7 R8 row sweep");
    end

    // R1 R5 R8 R11: random configurations with random vectors
    for (int c = 0; c < 12; c++) begin
      for (int b = 0; b < CB; b++) mdl[b] = ($urandom % 10) == 0;
      load_cfg(mdl); arm();
      for (int v = 0; v < 24; v++)
        apply(4'($urandom), 4'($urandom), 1'b1, "R1 R5 R11 random");
    end

    // R1: single literal rows, true vs complement of input 2 in group 0
    mdl = '1;
    for (int j = 0; j < NL; j++) mdl[j] = 1'b0;
    mdl[2*2] = 1'b1;
    load_cfg(mdl); arm();
    apply(4'h4, 4'h0, 1'b1, "R1 true literal");
    apply(4'h0, 4'h0, 1'b1, "R1 true literal");
    mdl[2*2] = 1'b0; mdl[2*2+1] = 1'b1;
    load_cfg(mdl); arm();
    apply(4'h4, 4'h0, 1'b1, "R1 complement literal");
    apply(4'h0, 4'h0, 1'b1, "R1 complement literal");

    // R9: shift and load together blank the array
    mdl = '0;
    load_cfg(mdl); arm();
    apply(4'h1, 4'h2, 1'b1, "R9 armed before");
    @(negedge clk); sh = 1'b1; ld = 1'b1; cbit = 1'b0;
    @(negedge clk); sh = 1'b0; ld = 1'b0;
    #1 chk("R9 shift beats load", '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule